// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line in one processor's cache that sits on a shared snooping bus. It uses a four-state invalidation protocol: Modified, Exclusive, Shared and Invalid. The processor side presents read and write requests. The block looks up its own tag/state store to decide hit or miss. It then issues the bus transaction the protocol needs: a plain read, a read-for-ownership, or an upgrade that announces intent to write. It records the new state of the line at the next clock edge. For a read miss, the bus returns a shared-line response in the same cycle as the request, and that response selects Exclusive or Shared.

The bus side watches reads and intent-to-write transactions from other masters. These lookups use a second read port of the tag/state store, so snooping never costs the processor a cycle. The block raises its own shared-line response for reads that hit. When a snoop finds a dirty line, the block signals an intervention in the following cycle, so that it supplies the data and memory's stale reply is suppressed. A processor access that touches the same line as a snoop in the same cycle is stalled for that cycle.

Data storage, victim handling on replacement and bus arbitration are handled outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. For any address, `cpu_hit` reads 0 and `cpu_state` reads Invalid. The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: An accepted read that misses drives `bus_req_op`=1 (read) with `bus_req_addr` equal to the request address. The line is then installed as Exclusive if `bus_shared_in` was low in that cycle, or as Shared if it was high. The address is split as follows: the low log2(LINES) bits are the line index and the upper bits are the tag.
- R3: An accepted write that hits an Exclusive line makes the line Modified with `bus_req_op`=0 (none). Reads that hit any valid line, and writes that hit a Modified line, also issue no bus request and leave the state unchanged.
- R4: An accepted write that hits a Shared line drives `bus_req_op`=3 (upgrade), and the line becomes Modified.
- R5: An accepted write that misses drives `bus_req_op`=2 (read-for-ownership), and the line is installed as Modified.
- R6: A snooped read that hits a valid line raises `snp_shared_out` in the same cycle and leaves the line Shared. If the line was Modified, then in the next cycle only `intervene` and `wb_req` are high for one cycle, and `intervene_idx` carries the line index.
- R7: A snooped intent-to-write (`snp_itw`=1) that hits a valid line makes it Invalid and does not raise `snp_shared_out`. If the line was Modified, `intervene` is high in the next cycle with the line index, and `wb_req` stays low.
- R8: A snoop that misses the tag store changes no state and raises none of `snp_shared_out`, `intervene` or `wb_req`.
- R9: When a processor request and a snoop address the same line index in one cycle, `cpu_ready` is low, no bus request is issued, and the request has no effect. The snoop's update is visible in the next cycle.
- R10: A processor request and a snoop to different line indexes in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | Request is a write (0 = read) |
| cpu_addr | input | ADDR_W | Request line address; also the lookup address for `cpu_hit`/`cpu_state` |
| cpu_ready | output | 1 | Request accepted this cycle (low on a same-line snoop collision) |
| cpu_hit | output | 1 | Tag matches and the line is valid |
| cpu_state | output | 2 | Current state of the addressed line |
| bus_shared_in | input | 1 | Shared-line response from other caches, sampled on a read miss |
| bus_req_op | output | 2 | Bus request: 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| bus_req_addr | output | ADDR_W | Address of the bus request, zero when none |
| snp_valid | input | 1 | Another master's transaction is being snooped |
| snp_itw | input | 1 | Snooped transaction is an intent-to-write (0 = read) |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared_out | output | 1 | This cache holds the snooped line for a read |
| intervene | output | 1 | One-cycle request to supply dirty data in place of memory |
| intervene_idx | output | log2(LINES) | Line index for the intervention |
| wb_req | output | 1 | Dirty data must also be written back to memory |

## Verification
The hardest case to reach is a collision: a processor access and a snoop must arrive at the same line in the same cycle, while the line is in a state where the processor's access would itself change it. The stimulus first drives the line to Shared and then issues a local write together with a snooped intent-to-write. Without the stall, this collision would leave the line Modified instead of Invalid. A second collision uses a different tag at the same index against a Modified line, which checks that the interlock works on index and that the intervention still fires. The dual-port case pairs a read miss with an intent-to-write snoop on a dirty line at another index, and the bench checks both outcomes.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_READ = 2'd1,
        BUS_RFO  = 2'd2,
        BUS_UPGR = 2'd3
    } bus_op_e;

    typedef struct packed {
        line_state_e nxt;
        bus_op_e     op;
    } cpu_dec_t;

    typedef struct packed {
        line_state_e nxt;
        logic        supply;
        logic        flush;
        logic        shared;
    } snp_dec_t;

    // Local access: pick the bus transaction and the resulting state.
    function automatic cpu_dec_t cpu_decide(logic hit, line_state_e cur,
                                            logic wr, logic others_share);
        cpu_dec_t d;
        d.nxt = cur;
        d.op  = BUS_NONE;
        if (!hit) begin
            if (wr) begin
                d.op  = BUS_RFO;
                d.nxt = ST_M;
            end else begin
                d.op  = BUS_READ;
                d.nxt = others_share ? ST_S : ST_E;
            end
        end else begin
            unique case (cur)
                ST_M: d.nxt = ST_M;
                ST_E: d.nxt = wr ? ST_M : ST_E;
                ST_S: begin
                    if (wr) begin
                        d.op  = BUS_UPGR;
                        d.nxt = ST_M;
                    end
                end
                default: d.nxt = cur;
            endcase
        end
        return d;
    endfunction

    // Remote transaction: state change and responses of this cache.
    function automatic snp_dec_t snp_decide(logic hit, line_state_e cur, logic itw);
        snp_dec_t d;
        d.nxt    = cur;
        d.supply = 1'b0;
        d.flush  = 1'b0;
        d.shared = 1'b0;
        if (hit) begin
            if (itw) begin
                d.nxt    = ST_I;
                d.supply = (cur == ST_M);
            end else begin
                d.shared = 1'b1;
                if (cur == ST_M) begin
                    d.supply = 1'b1;
                    d.flush  = 1'b1;
                    d.nxt    = ST_S;
                end else if (cur == ST_E) begin
                    d.nxt = ST_S;
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    // processor-side read port
    input  logic [IDX_W-1:0] p_ridx,
    output logic [TAG_W-1:0] p_rtag,
    output line_state_e      p_rst,
    // snoop-side read port
    input  logic [IDX_W-1:0] s_ridx,
    output logic [TAG_W-1:0] s_rtag,
    output line_state_e      s_rst,
    // processor-side write (tag and state)
    input  logic             p_we,
    input  logic [IDX_W-1:0] p_widx,
    input  logic [TAG_W-1:0] p_wtag,
    input  line_state_e      p_wst,
    // snoop-side write (state only)
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_widx,
    input  line_state_e      s_wst
);

    logic [TAG_W-1:0] tag_q [LINES];
    line_state_e      st_q  [LINES];

    assign p_rtag = tag_q[p_ridx];
    assign p_rst  = st_q[p_ridx];
    assign s_rtag = tag_q[s_ridx];
    assign s_rst  = st_q[s_ridx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else begin
            if (p_we) begin
                tag_q[p_widx] <= p_wtag;
                st_q[p_widx]  <= p_wst;
            end
            if (s_we && !(p_we && (p_widx == s_widx))) begin
                st_q[s_widx] <= s_wst;
            end
        end
    end

endmodule

// File: rtl/mesi_cpu_ctrl.sv
module mesi_cpu_ctrl
    import mesi_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             hold,
    input  logic             others_share,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] rd_tag,
    input  line_state_e      rd_st,
    output logic             hit,
    output line_state_e      cur_state,
    output logic             accept,
    output bus_op_e          op,
    output logic             we,
    output line_state_e      wst
);

    cpu_dec_t dec;

    assign hit       = (rd_tag == req_tag) && (rd_st != ST_I);
    assign cur_state = hit ? rd_st : ST_I;
    assign accept    = req_valid && !hold;
    assign dec       = cpu_decide(hit, rd_st, req_write, others_share);
    assign op        = accept ? dec.op : BUS_NONE;
    assign we        = accept;
    assign wst       = dec.nxt;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int TAG_W = 9,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  logic             snp_itw,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  line_state_e      rd_st,
    output logic             shared_out,
    output logic             we,
    output line_state_e      wst,
    output logic             supply_q,
    output logic [IDX_W-1:0] supply_idx_q,
    output logic             flush_q
);

    logic     hit;
    snp_dec_t dec;

    assign hit        = snp_valid && (rd_tag == snp_tag) && (rd_st != ST_I);
    assign dec        = snp_decide(hit, rd_st, snp_itw);
    assign shared_out = dec.shared;
    assign we         = hit;
    assign wst        = dec.nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            supply_q     <= 1'b0;
            flush_q      <= 1'b0;
            supply_idx_q <= '0;
        end else begin
            supply_q <= dec.supply;
            flush_q  <= dec.flush;
            if (dec.supply) begin
                supply_idx_q <= snp_idx;
            end
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [1:0]        cpu_state,
    input  logic              bus_shared_in,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              snp_valid,
    input  logic              snp_itw,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared_out,
    output logic              intervene,
    output logic [IDX_W-1:0]  intervene_idx,
    output logic              wb_req
);

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic [TAG_W-1:0] p_rtag, s_rtag;
    line_state_e      p_rst, s_rst;
    logic             collide;
    logic             c_accept, c_we, s_we;
    line_state_e      c_wst, s_wst, c_cur;
    bus_op_e          c_op;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    // Same-line interlock: the snoop wins, the processor waits a cycle.
    assign collide = cpu_valid && snp_valid && (c_idx == s_idx);

    mesi_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .p_ridx (c_idx),
        .p_rtag (p_rtag),
        .p_rst  (p_rst),
        .s_ridx (s_idx),
        .s_rtag (s_rtag),
        .s_rst  (s_rst),
        .p_we   (c_we),
        .p_widx (c_idx),
        .p_wtag (c_tag),
        .p_wst  (c_wst),
        .s_we   (s_we),
        .s_widx (s_idx),
        .s_wst  (s_wst)
    );

    mesi_cpu_ctrl #(.TAG_W(TAG_W)) u_cpu (
        .req_valid    (cpu_valid),
        .req_write    (cpu_write),
        .hold         (collide),
        .others_share (bus_shared_in),
        .req_tag      (c_tag),
        .rd_tag       (p_rtag),
        .rd_st        (p_rst),
        .hit          (cpu_hit),
        .cur_state    (c_cur),
        .accept       (c_accept),
        .op           (c_op),
        .we           (c_we),
        .wst          (c_wst)
    );

    mesi_snoop_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_snoop (
        .clk          (clk),
        .rst          (rst),
        .snp_valid    (snp_valid),
        .snp_itw      (snp_itw),
        .snp_tag      (s_tag),
        .snp_idx      (s_idx),
        .rd_tag       (s_rtag),
        .rd_st        (s_rst),
        .shared_out   (snp_shared_out),
        .we           (s_we),
        .wst          (s_wst),
        .supply_q     (intervene),
        .supply_idx_q (intervene_idx),
        .flush_q      (wb_req)
    );

    assign cpu_ready    = !collide;
    assign cpu_state    = c_cur;
    assign bus_req_op   = c_op;
    assign bus_req_addr = (c_accept && (c_op != BUS_NONE)) ? cpu_addr : '0;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_write,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic [1:0]        cpu_state,
    input logic [1:0]        bus_req_op,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              intervene,
    input logic              wb_req
);

    logic acc;
    assign acc = cpu_valid && cpu_ready;

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_hit);

    a_r2_read_miss_reads: assert property (@(posedge clk) disable iff (rst)
        (acc && !cpu_write && !cpu_hit) |-> (bus_req_op == 2'd1));

    a_r3_exclusive_write_silent: assert property (@(posedge clk) disable iff (rst)
        (acc && cpu_write && cpu_hit && cpu_state == 2'd2) |-> (bus_req_op == 2'd0));

    a_r4_shared_write_upgrades: assert property (@(posedge clk) disable iff (rst)
        (acc && cpu_write && cpu_hit && cpu_state == 2'd1) |-> (bus_req_op == 2'd3));

    a_r5_write_miss_owns: assert property (@(posedge clk) disable iff (rst)
        (acc && cpu_write && !cpu_hit) |-> (bus_req_op == 2'd2));

    a_r6_flush_needs_supply: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> intervene);

    a_r6_supply_follows_snoop: assert property (@(posedge clk) disable iff (rst)
        intervene |-> $past(snp_valid));

    a_r9_same_line_stalls: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && snp_valid && cpu_addr[IDX_W-1:0] == snp_addr[IDX_W-1:0])
        |-> (!cpu_ready && bus_req_op == 2'd0));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_hit    (cpu_hit),
    .cpu_state  (cpu_state),
    .bus_req_op (bus_req_op),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .intervene  (intervene),
    .wb_req     (wb_req)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);

    localparam int SI = 0, SS = 1, SE = 2, SM = 3;
    localparam int OP_NONE = 0, OP_READ = 1, OP_RFO = 2, OP_UPGR = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_ready, cpu_hit;
    logic [1:0]        cpu_state;
    logic              bus_shared_in = 1'b0;
    logic [1:0]        bus_req_op;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              snp_valid = 1'b0, snp_itw = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared_out, intervene, wb_req;
    logic [IDX_W-1:0]  intervene_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES)) dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_state(cpu_state),
        .bus_shared_in(bus_shared_in), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
        .snp_valid(snp_valid), .snp_itw(snp_itw), .snp_addr(snp_addr),
        .snp_shared_out(snp_shared_out), .intervene(intervene),
        .intervene_idx(intervene_idx), .wb_req(wb_req)
    );

    typedef enum int {
        SIG_READY, SIG_HIT, SIG_STATE, SIG_OP, SIG_BADDR,
        SIG_SNPSH, SIG_INTV, SIG_INTVIDX, SIG_WB
    } sig_e;

    typedef struct {
        int    cyc;
        sig_e  sig;
        int    val;
        string req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    function automatic int sample(sig_e s);
        case (s)
            SIG_READY:   return int'(cpu_ready);
            SIG_HIT:     return int'(cpu_hit);
            SIG_STATE:   return int'(cpu_state);
            SIG_OP:      return int'(bus_req_op);
            SIG_BADDR:   return int'(bus_req_addr);
            SIG_SNPSH:   return int'(snp_shared_out);
            SIG_INTV:    return int'(intervene);
            SIG_INTVIDX: return int'(intervene_idx);
            default:     return int'(wb_req);
        endcase
    endfunction

    // Monitor: pops expectations that fall due and compares them.
    initial begin
        forever begin
            @(negedge clk);
            #1 cyc++;
            #2;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                int    act;
                it  = q.pop_front();
                act = sample(it.sig);
                checks++;
                if (act != it.val) begin
                    fails++;
                    $display("FAIL %s: %s actual %0d expected %0d (cycle %0d)",
                             it.req, it.sig.name(), act, it.val, cyc);
                end
            end
        end
    end

    // Driver side.
    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic expect_at(sig_e s, int v, string req, int delay);
        item_t it;
        it.cyc = cyc + delay;
        it.sig = s;
        it.val = v;
        it.req = req;
        q.push_back(it);
    endtask

    task automatic idle();
        cpu_valid     = 1'b0;
        cpu_write     = 1'b0;
        bus_shared_in = 1'b0;
        snp_valid     = 1'b0;
        snp_itw       = 1'b0;
    endtask

    task automatic cpu_req(bit w, logic [ADDR_W-1:0] a, bit sh);
        step();
        idle();
        cpu_valid     = 1'b1;
        cpu_write     = w;
        cpu_addr      = a;
        bus_shared_in = sh;
    endtask

    task automatic snoop(bit itw, logic [ADDR_W-1:0] a);
        step();
        idle();
        snp_valid = 1'b1;
        snp_itw   = itw;
        snp_addr  = a;
    endtask

    task automatic probe(logic [ADDR_W-1:0] a, int st, int hit, string req);
        step();
        idle();
        cpu_addr = a;
        expect_at(SIG_STATE, st, req, 0);
        expect_at(SIG_HIT, hit, req, 0);
    endtask

    localparam logic [ADDR_W-1:0] A0  = 12'h0A1;
    localparam logic [ADDR_W-1:0] A0X = 12'h1A1;
    localparam logic [ADDR_W-1:0] A2  = 12'h0B2;
    localparam logic [ADDR_W-1:0] A3  = 12'h0C3;
    localparam logic [ADDR_W-1:0] A4  = 12'h0D4;
    localparam logic [ADDR_W-1:0] A5  = 12'h0E5;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1: everything empty after reset
        probe(A0, SI, 0, "R1");
        probe(A5, SI, 0, "R1");
        expect_at(SIG_INTV, 0, "R1", 0);

        // R2: read miss, nobody shares -> Exclusive
        cpu_req(1'b0, A0, 1'b0);
        expect_at(SIG_READY, 1, "R2", 0);
        expect_at(SIG_OP, OP_READ, "R2", 0);
        expect_at(SIG_BADDR, int'(A0), "R2", 0);
        probe(A0, SE, 1, "R2");

        // R2: read miss, shared -> Shared
        cpu_req(1'b0, A2, 1'b1);
        expect_at(SIG_OP, OP_READ, "R2", 0);
        probe(A2, SS, 1, "R2");

        // R3: write hit Exclusive is silent -> Modified
        cpu_req(1'b1, A0, 1'b0);
        expect_at(SIG_OP, OP_NONE, "R3", 0);
        expect_at(SIG_BADDR, 0, "R3", 0);
        probe(A0, SM, 1, "R3");
        cpu_req(1'b0, A0, 1'b0);
        expect_at(SIG_OP, OP_NONE, "R3", 0);
        probe(A0, SM, 1, "R3");

        // R4: write hit Shared -> upgrade, Modified
        cpu_req(1'b1, A2, 1'b0);
        expect_at(SIG_OP, OP_UPGR, "R4", 0);
        expect_at(SIG_BADDR, int'(A2), "R4", 0);
        probe(A2, SM, 1, "R4");

        // R5: write miss -> read-for-ownership, Modified
        cpu_req(1'b1, A3, 1'b1);
        expect_at(SIG_OP, OP_RFO, "R5", 0);
        expect_at(SIG_BADDR, int'(A3), "R5", 0);
        probe(A3, SM, 1, "R5");

        // R6: snooped read of a Modified line
        snoop(1'b0, A0);
        expect_at(SIG_SNPSH, 1, "R6", 0);
        expect_at(SIG_INTV, 0, "R6", 0);
        probe(A0, SS, 1, "R6");
        expect_at(SIG_INTV, 1, "R6", 0);
        expect_at(SIG_INTVIDX, 1, "R6", 0);
        expect_at(SIG_WB, 1, "R6", 0);
        probe(A0, SS, 1, "R6");
        expect_at(SIG_INTV, 0, "R6", 0);
        expect_at(SIG_WB, 0, "R6", 0);

        // R6: snooped read of an Exclusive line
        cpu_req(1'b0, A4, 1'b0);
        expect_at(SIG_OP, OP_READ, "R6", 0);
        snoop(1'b0, A4);
        expect_at(SIG_SNPSH, 1, "R6", 0);
        probe(A4, SS, 1, "R6");
        expect_at(SIG_INTV, 0, "R6", 0);

        // R7: intent-to-write on Modified and on Shared lines
        snoop(1'b1, A2);
        expect_at(SIG_SNPSH, 0, "R7", 0);
        probe(A2, SI, 0, "R7");
        expect_at(SIG_INTV, 1, "R7", 0);
        expect_at(SIG_INTVIDX, 2, "R7", 0);
        expect_at(SIG_WB, 0, "R7", 0);
        snoop(1'b1, A4);
        probe(A4, SI, 0, "R7");
        expect_at(SIG_INTV, 0, "R7", 0);

        // R8: snoop to same index, other tag: no response, no change
        snoop(1'b0, A0X);
        expect_at(SIG_SNPSH, 0, "R8", 0);
        probe(A0, SS, 1, "R8");
        expect_at(SIG_INTV, 0, "R8", 0);
        expect_at(SIG_WB, 0, "R8", 0);
        snoop(1'b1, A0X);
        probe(A0, SS, 1, "R8");
        expect_at(SIG_INTV, 0, "R8", 0);

        // R9: local write and remote intent-to-write collide on A0 (Shared)
        step();
        idle();
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = A0;
        snp_valid = 1'b1; snp_itw = 1'b1;   snp_addr = A0;
        expect_at(SIG_READY, 0, "R9", 0);
        expect_at(SIG_OP, OP_NONE, "R9", 0);
        probe(A0, SI, 0, "R9");
        cpu_req(1'b1, A0, 1'b0);
        expect_at(SIG_READY, 1, "R9", 0);
        expect_at(SIG_OP, OP_RFO, "R9", 0);
        probe(A0, SM, 1, "R9");

        // R9: same index, other tag, against a Modified line
        step();
        idle();
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = A0X;
        snp_valid = 1'b1; snp_itw = 1'b0;   snp_addr = A0;
        expect_at(SIG_READY, 0, "R9", 0);
        expect_at(SIG_OP, OP_NONE, "R9", 0);
        expect_at(SIG_SNPSH, 1, "R9", 0);
        probe(A0, SS, 1, "R9");
        expect_at(SIG_INTV, 1, "R9", 0);
        expect_at(SIG_WB, 1, "R9", 0);
        probe(A0X, SI, 0, "R9");

        // R10: read miss and intent-to-write snoop on different lines together
        step();
        idle();
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = A5; bus_shared_in = 1'b1;
        snp_valid = 1'b1; snp_itw = 1'b1;   snp_addr = A3;
        expect_at(SIG_READY, 1, "R10", 0);
        expect_at(SIG_OP, OP_READ, "R10", 0);
        expect_at(SIG_BADDR, int'(A5), "R10", 0);
        probe(A5, SS, 1, "R10");
        expect_at(SIG_INTV, 1, "R10", 0);
        expect_at(SIG_INTVIDX, 3, "R10", 0);
        probe(A3, SI, 0, "R10");

        step();
        idle();
        repeat (3) step();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished (cycle %0d)", cyc);
            finish_run();
        end
    end

endmodule